// File: doc/BRIEF.md
# Banked Memory Slave with Programmable Wait States

This block is an AHB-Lite slave that stands in for a set of memory banks behind a bus. The number of banks is a parameter, six by default. Each bank has four configuration inputs: a first byte address, a last byte address, a wait count for the opening (NONSEQ) beat of a transfer, and a second wait count for each later (SEQ) beat of a burst. The slave finds the bank for each beat and holds `hreadyout` low for that many cycles. It then does a little-endian byte, halfword or word read or write into the bank's word storage.

Address and control are taken from the bus only on a NONSEQ beat. Each SEQ beat uses an address the slave steps forward itself, wrapping for wrapping bursts. The slave does no protocol checking and always answers OKAY. A read outside every configured bank returns zero, and a write outside them is dropped. Each completed data phase also shows one record on the `rec_*` outputs: the address, the direction, the size, and the data limited to the active byte lanes. A testbench or a log can watch this record.

Top module: `bkm_ahb_slave`

## Requirements
- R1: While reset is asserted and after it is released, `hreadyout` is 1, `hresp` is 0, `rec_valid` is 0, and every storage word reads as zero.
- R2: A bank whose last-address field is zero is unused. Any other bank is hit when first <= address <= last, and its storage word is (address - first)/4 modulo DEPTH.
- R3: A NONSEQ beat (HTRANS=2) accepted into bank b holds `hreadyout` low for exactly the first-access wait count of b, counted in cycles of its data phase.
- R4: A SEQ beat (HTRANS=3) accepted into bank b holds `hreadyout` low for exactly the later-beat wait count of b.
- R5: On a SEQ beat, `haddr`, `hwrite`, `hsize` and `hburst` are ignored. The beat uses the previous beat's address plus 1<<size, with the direction and size of the burst's NONSEQ beat.
- R6: For WRAP4, WRAP8 and WRAP16 (HBURST 2, 4, 6), the stepped address wraps inside an aligned block of beats x (1<<size) bytes. For SINGLE and INCR codes (0, 1, 3, 5, 7) it counts upward.
- R7: Lanes are little-endian, with HSIZE 0 = byte, 1 = halfword, 2 = word. Byte offset k uses bits 8k+7..8k. A halfword at offset 0 uses [15:0] and one at offset 2 uses [31:16]. A write changes only those lanes. `hrdata` returns the whole addressed word.
- R8: In the last cycle of each data phase (`hreadyout` 1), `rec_valid` is 1 for that cycle only. `rec_addr`, `rec_write` and `rec_size` then give the beat, and `rec_data` gives the write or read data with the inactive lanes set to zero.
- R9: `hresp` is 0 (OKAY) for every transfer, whether or not it hits a bank.
- R10: IDLE (HTRANS=0) and BUSY (HTRANS=1) beats start no data phase. They produce no record and change no storage.
- R11: A beat that hits no bank has no wait cycles. A read returns zero, and a write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| haddr | input | AW | Byte address (address phase) |
| htrans | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| hwrite | input | 1 | 1 write, 0 read |
| hsize | input | 3 | 0 byte, 1 halfword, 2 word |
| hburst | input | 3 | Burst code |
| hwdata | input | 32 | Write data (data phase) |
| hready | input | 1 | Bus ready seen by all slaves |
| hreadyout | output | 1 | Low while this slave inserts wait cycles |
| hresp | output | 1 | Response, always OKAY |
| hrdata | output | 32 | Read data, word containing the beat |
| cfg_start | input | NB*AW | Per-bank first byte address |
| cfg_end | input | NB*AW | Per-bank last byte address, zero = unused |
| cfg_wait_first | input | NB*WW | Per-bank wait cycles on NONSEQ beats |
| cfg_wait_next | input | NB*WW | Per-bank wait cycles on SEQ beats |
| rec_valid | output | 1 | Record strobe at data phase completion |
| rec_addr | output | AW | Beat byte address |
| rec_write | output | 1 | Beat direction |
| rec_size | output | 3 | Beat size |
| rec_data | output | 32 | Beat data on its active lanes |

## Verification
The assertions assume a single-slave system, so `hready` follows `hreadyout`. No new address phase is offered while a wait is in progress. The bank configuration holds steady and has no overlaps. The bench ties `hready` to `hreadyout` and loads the configuration before reset is released. It presents each address phase only at a falling edge where `hreadyout` is high, and it fills gaps inside bursts with BUSY and ends bursts with IDLE.

// File: rtl/bkm_pkg.sv
package bkm_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    localparam logic [1:0] TR_IDLE = 2'd0;
    localparam logic [1:0] TR_BUSY = 2'd1;
    localparam logic [1:0] TR_NSEQ = 2'd2;
    localparam logic [1:0] TR_SEQ  = 2'd3;

    typedef enum logic [2:0] {
        BU_SINGLE = 3'd0,
        BU_INCR   = 3'd1,
        BU_WRAP4  = 3'd2,
        BU_INCR4  = 3'd3,
        BU_WRAP8  = 3'd4,
        BU_INCR8  = 3'd5,
        BU_WRAP16 = 3'd6,
        BU_INCR16 = 3'd7
    } burst_e;

    // Active byte lanes for a beat, little-endian.
    function automatic logic [LANES-1:0] lane_mask(input logic [1:0] off, input logic [2:0] sz);
        logic [LANES-1:0] m;
        case (sz)
            3'd0:    m = LANES'(1) << off;
            3'd1:    m = off[1] ? 4'b1100 : 4'b0011;
            default: m = '1;
        endcase
        return m;
    endfunction

    // Spread a lane mask to a bit mask.
    function automatic logic [DATA_W-1:0] lane_bits(input logic [LANES-1:0] m);
        logic [DATA_W-1:0] b;
        for (int k = 0; k < LANES; k++) begin
            b[8*k +: 8] = {8{m[k]}};
        end
        return b;
    endfunction

endpackage

// File: rtl/bkm_burst_step.sv
module bkm_burst_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [2:0]    size,
    input  logic [2:0]    burst,
    output logic [AW-1:0] nxt_addr
);
    import bkm_pkg::*;

    logic [AW-1:0] step;
    logic [AW-1:0] inc;
    logic [AW-1:0] span;
    logic [AW-1:0] wmask;
    logic          wrap;

    always_comb begin
        step = AW'(1) << size;
        inc  = cur_addr + step;
        wrap = 1'b1;
        case (burst_e'(burst))
            BU_WRAP4:  span = step << 2;
            BU_WRAP8:  span = step << 3;
            BU_WRAP16: span = step << 4;
            default: begin
                span = '0;
                wrap = 1'b0;
            end
        endcase
        wmask = span - AW'(1);
        if (wrap) begin
            nxt_addr = (cur_addr & ~wmask) | (inc & wmask);
        end else begin
            nxt_addr = inc;
        end
    end

endmodule

// File: rtl/bkm_bank_decode.sv
module bkm_bank_decode #(
    parameter int NB   = 6,
    parameter int AW   = 32,
    parameter int IDXW = 6,
    parameter int BW   = 3
) (
    input  logic [AW-1:0]    addr,
    input  logic [NB*AW-1:0] cfg_start,
    input  logic [NB*AW-1:0] cfg_end,
    output logic             hit,
    output logic [BW-1:0]    bank,
    output logic [IDXW-1:0]  idx
);
    logic [AW-1:0] off;
    logic          unused_off_bits;

    // Walk from the top so the lowest matching bank wins.
    always_comb begin
        hit  = 1'b0;
        bank = '0;
        off  = '0;
        for (int b = NB - 1; b >= 0; b--) begin
            if ((cfg_end[b*AW +: AW] != '0) &&
                (addr >= cfg_start[b*AW +: AW]) &&
                (addr <= cfg_end[b*AW +: AW])) begin
                hit  = 1'b1;
                bank = BW'(b);
                off  = addr - cfg_start[b*AW +: AW];
            end
        end
        idx = off[IDXW+1:2];
    end

    assign unused_off_bits = ^{off[AW-1:IDXW+2], off[1:0]};

endmodule

// File: rtl/bkm_bank_store.sv
module bkm_bank_store #(
    parameter int NB    = 6,
    parameter int DEPTH = 64,
    parameter int IDXW  = 6,
    parameter int BW    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [BW-1:0]              wr_bank,
    input  logic [IDXW-1:0]            wr_idx,
    input  logic [bkm_pkg::LANES-1:0]  wr_be,
    input  logic [bkm_pkg::DATA_W-1:0] wr_data,
    input  logic [BW-1:0]              rd_bank,
    input  logic [IDXW-1:0]            rd_idx,
    output logic [bkm_pkg::DATA_W-1:0] rd_data
);
    import bkm_pkg::*;

    localparam int NSLOT = 1 << BW;

    logic [DATA_W-1:0] bank_rd [NSLOT];

    for (genvar b = 0; b < NSLOT; b++) begin : g_bank
        if (b < NB) begin : g_used
            logic [DATA_W-1:0] mem [DEPTH];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        mem[i] <= '0;
                    end
                end else if (wr_en && (wr_bank == BW'(b))) begin
                    for (int k = 0; k < LANES; k++) begin
                        if (wr_be[k]) begin
                            mem[wr_idx][8*k +: 8] <= wr_data[8*k +: 8];
                        end
                    end
                end
            end

            assign bank_rd[b] = mem[rd_idx];
        end else begin : g_empty
            assign bank_rd[b] = '0;
        end
    end

    assign rd_data = bank_rd[rd_bank];

endmodule

// File: rtl/bkm_ahb_slave.sv
module bkm_ahb_slave #(
    parameter int NB    = 6,
    parameter int AW    = 32,
    parameter int DEPTH = 64,
    parameter int WW    = 8
) (
    input  logic             hclk,
    input  logic             hresetn,
    input  logic             hsel,
    input  logic [AW-1:0]    haddr,
    input  logic [1:0]       htrans,
    input  logic             hwrite,
    input  logic [2:0]       hsize,
    input  logic [2:0]       hburst,
    input  logic [31:0]      hwdata,
    input  logic             hready,
    output logic             hreadyout,
    output logic             hresp,
    output logic [31:0]      hrdata,
    input  logic [NB*AW-1:0] cfg_start,
    input  logic [NB*AW-1:0] cfg_end,
    input  logic [NB*WW-1:0] cfg_wait_first,
    input  logic [NB*WW-1:0] cfg_wait_next,
    output logic             rec_valid,
    output logic [AW-1:0]    rec_addr,
    output logic             rec_write,
    output logic [2:0]       rec_size,
    output logic [31:0]      rec_data
);
    import bkm_pkg::*;

    localparam int BW   = (NB > 1) ? $clog2(NB) : 1;
    localparam int IDXW = $clog2(DEPTH);

    typedef struct packed {
        logic            dph;
        logic            wr;
        logic [2:0]      size;
        logic [2:0]      burst;
        logic [AW-1:0]   addr;
        logic            hit;
        logic [BW-1:0]   bank;
        logic [IDXW-1:0] idx;
        logic [WW-1:0]   wcnt;
    } st_t;

    st_t st_d, st_q;

    logic            accept;
    logic            is_seq;
    logic            done;
    logic [AW-1:0]   step_addr;
    logic [AW-1:0]   a_addr;
    logic            a_wr;
    logic [2:0]      a_size;
    logic [2:0]      a_burst;
    logic            dec_hit;
    logic [BW-1:0]   dec_bank;
    logic [IDXW-1:0] dec_idx;
    logic [WW-1:0]   load_wait;
    logic [LANES-1:0]  be;
    logic [DATA_W-1:0] rd_word;
    logic            dph_q;

    assign accept = hsel && htrans[1] && hready;
    assign is_seq = (htrans == TR_SEQ);

    bkm_burst_step #(.AW(AW)) u_step (
        .cur_addr (st_q.addr),
        .size     (st_q.size),
        .burst    (st_q.burst),
        .nxt_addr (step_addr)
    );

    // Bus control is only taken on NONSEQ; SEQ reuses the burst state.
    assign a_addr  = is_seq ? step_addr  : haddr;
    assign a_wr    = is_seq ? st_q.wr    : hwrite;
    assign a_size  = is_seq ? st_q.size  : hsize;
    assign a_burst = is_seq ? st_q.burst : hburst;

    bkm_bank_decode #(.NB(NB), .AW(AW), .IDXW(IDXW), .BW(BW)) u_dec (
        .addr      (a_addr),
        .cfg_start (cfg_start),
        .cfg_end   (cfg_end),
        .hit       (dec_hit),
        .bank      (dec_bank),
        .idx       (dec_idx)
    );

    assign load_wait = !dec_hit ? '0 :
                       is_seq   ? cfg_wait_next[dec_bank*WW +: WW]
                                : cfg_wait_first[dec_bank*WW +: WW];

    always_comb begin
        st_d = st_q;
        done = st_q.dph && (st_q.wcnt == '0);
        if (st_q.dph && (st_q.wcnt != '0)) begin
            st_d.wcnt = st_q.wcnt - 1'b1;
        end
        if (done) begin
            st_d.dph = 1'b0;
        end
        if (accept) begin
            st_d.dph   = 1'b1;
            st_d.wr    = a_wr;
            st_d.size  = a_size;
            st_d.burst = a_burst;
            st_d.addr  = a_addr;
            st_d.hit   = dec_hit;
            st_d.bank  = dec_bank;
            st_d.idx   = dec_idx;
            st_d.wcnt  = load_wait;
        end
    end

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign be = lane_mask(st_q.addr[1:0], st_q.size);

    bkm_bank_store #(.NB(NB), .DEPTH(DEPTH), .IDXW(IDXW), .BW(BW)) u_store (
        .clk     (hclk),
        .rst_n   (hresetn),
        .wr_en   (done && st_q.wr && st_q.hit),
        .wr_bank (st_q.bank),
        .wr_idx  (st_q.idx),
        .wr_be   (be),
        .wr_data (hwdata),
        .rd_bank (st_q.bank),
        .rd_idx  (st_q.idx),
        .rd_data (rd_word)
    );

    assign dph_q     = st_q.dph;
    assign hreadyout = !st_q.dph || (st_q.wcnt == '0);
    assign hresp     = 1'b0;
    assign hrdata    = (st_q.dph && !st_q.wr && st_q.hit) ? rd_word : '0;

    assign rec_valid = done;
    assign rec_addr  = st_q.addr;
    assign rec_write = st_q.wr;
    assign rec_size  = st_q.size;
    assign rec_data  = (st_q.wr ? hwdata : hrdata) & lane_bits(be);

endmodule

// File: rtl/bkm_ahb_slave_chk.sv
module bkm_ahb_slave_chk #(
    parameter int NB = 6,
    parameter int AW = 32,
    parameter int WW = 8
) (
    input logic             hclk,
    input logic             hresetn,
    input logic             hsel,
    input logic [1:0]       htrans,
    input logic             hready,
    input logic             hreadyout,
    input logic             rec_valid,
    input logic [AW-1:0]    rec_addr,
    input logic             dph_q,
    input logic             dec_hit,
    input logic [((NB > 1) ? $clog2(NB) : 1)-1:0] dec_bank,
    input logic [NB*WW-1:0] cfg_wait_first
);
    logic acc;
    assign acc = hsel && htrans[1] && hready;

    AST_IDLE_READY: assert property (@(posedge hclk) disable iff (!hresetn)
        !dph_q |-> hreadyout); // R3

    AST_RECORD_ON_READY: assert property (@(posedge hclk) disable iff (!hresetn)
        rec_valid |-> hreadyout); // R8

    AST_STALL_KEEPS_ADDR: assert property (@(posedge hclk) disable iff (!hresetn)
        (dph_q && !hreadyout) |=> $stable(rec_addr)); // R8

    AST_FIRST_WAIT_STALLS: assert property (@(posedge hclk) disable iff (!hresetn)
        (acc && htrans == 2'd2 && dec_hit && cfg_wait_first[dec_bank*WW +: WW] != '0)
        |=> !hreadyout); // R3

    AST_IDLE_NO_RECORD: assert property (@(posedge hclk) disable iff (!hresetn)
        (hsel && !htrans[1] && hready) |=> !rec_valid); // R10

    AST_MISS_NO_WAIT: assert property (@(posedge hclk) disable iff (!hresetn)
        (acc && !dec_hit) |=> hreadyout); // R11

endmodule

bind bkm_ahb_slave bkm_ahb_slave_chk #(.NB(NB), .AW(AW), .WW(WW)) u_chk (
    .hclk           (hclk),
    .hresetn        (hresetn),
    .hsel           (hsel),
    .htrans         (htrans),
    .hready         (hready),
    .hreadyout      (hreadyout),
    .rec_valid      (rec_valid),
    .rec_addr       (rec_addr),
    .dph_q          (dph_q),
    .dec_hit        (dec_hit),
    .dec_bank       (dec_bank),
    .cfg_wait_first (cfg_wait_first)
);

// File: tb/tb_bkm_ahb_slave.sv
`timescale 1ns/1ps
module tb_bkm_ahb_slave;

    localparam int NB = 6;
    localparam int AW = 32;
    localparam int WW = 8;

    logic             clk = 1'b0;
    logic             hresetn;
    logic             hsel;
    logic [AW-1:0]    haddr;
    logic [1:0]       htrans;
    logic             hwrite;
    logic [2:0]       hsize;
    logic [2:0]       hburst;
    logic [31:0]      hwdata;
    logic             hready;
    logic             hreadyout;
    logic             hresp;
    logic [31:0]      hrdata;
    logic [NB*AW-1:0] cfg_start;
    logic [NB*AW-1:0] cfg_end;
    logic [NB*WW-1:0] cfg_wait_first;
    logic [NB*WW-1:0] cfg_wait_next;
    logic             rec_valid;
    logic [AW-1:0]    rec_addr;
    logic             rec_write;
    logic [2:0]       rec_size;
    logic [31:0]      rec_data;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  finished = 0;

    always #4 clk = ~clk;
    assign hready = hreadyout;

    bkm_ahb_slave dut (
        .hclk(clk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hwdata(hwdata),
        .hready(hready), .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
        .cfg_start(cfg_start), .cfg_end(cfg_end),
        .cfg_wait_first(cfg_wait_first), .cfg_wait_next(cfg_wait_next),
        .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_write(rec_write),
        .rec_size(rec_size), .rec_data(rec_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One beat: address phase, then the data phase until hreadyout is high.
    task automatic xfer(input logic [1:0] tr, input logic [31:0] a, input logic wr,
                        input logic [2:0] sz, input logic [2:0] bu, input logic [31:0] wd,
                        input logic [1:0] gap, output logic [31:0] rd, output int w,
                        output logic rv, output logic [31:0] ra, output logic [31:0] rdat);
        @(negedge clk);
        hsel = 1'b1; htrans = tr; haddr = a; hwrite = wr; hsize = sz; hburst = bu;
        @(posedge clk);
        #1;
        htrans = gap;
        hwdata = wd;
        @(negedge clk);
        w = 0;
        while (hreadyout !== 1'b1 && w < 100) begin
            w++;
            @(negedge clk);
        end
        rd = hrdata; rv = rec_valid; ra = rec_addr; rdat = rec_data;
        chk("R9 hresp", {31'd0, hresp}, 32'd0);
    endtask

    task automatic single(input logic [31:0] a, input logic wr, input logic [2:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd, output int w,
                          output logic [31:0] rdat);
        logic rv;
        logic [31:0] ra;
        xfer(2'd2, a, wr, sz, 3'd0, wd, 2'd0, rd, w, rv, ra, rdat);
        chk("R8 rec_valid", {31'd0, rv}, 32'd1);
        chk("R8 rec_addr", ra, a);
    endtask

    task automatic t_reset();
        logic [31:0] rd, rdat;
        int w;
        chk("R1 hreadyout", {31'd0, hreadyout}, 32'd1);
        chk("R1 rec_valid", {31'd0, rec_valid}, 32'd0);
        chk("R1 hresp", {31'd0, hresp}, 32'd0);
        @(negedge clk);
        hresetn = 1'b1;
        single(32'h0000_0040, 1'b0, 3'd2, 32'h0, rd, w, rdat);
        chk("R1 storage zero", rd, 32'h0);
    endtask

    task automatic t_zero_wait();
        logic [31:0] rd, rdat;
        int w;
        single(32'h0000_0008, 1'b1, 3'd2, 32'hA5A5_5A5A, rd, w, rdat);
        chk("R3 zero waits", w, 0);
        chk("R8 write data", rdat, 32'hA5A5_5A5A);
        chk("R8 rec_write", {31'd0, rec_write}, 32'd1);
        single(32'h0000_0008, 1'b0, 3'd2, 32'h0, rd, w, rdat);
        chk("R7 word read", rd, 32'hA5A5_5A5A);
        chk("R8 rec_write read", {31'd0, rec_write}, 32'd0);
    endtask

    task automatic t_byte_lanes();
        logic [31:0] rd, rdat;
        int w;
        for (int k = 0; k < 4; k++) begin
            single(32'h0000_1000 + k, 1'b1, 3'd0, 32'h0F0F_0F0F, rd, w, rdat);
            chk("R3 first waits bank1", w, 2);
            chk("R8 byte lane data", rdat, 32'h0000_000F << (8 * k));
            chk("R8 rec_size", {29'd0, rec_size}, 32'd0);
        end
        single(32'h0000_1000, 1'b0, 3'd2, 32'h0, rd, w, rdat);
        chk("R7 bytes assemble", rd, 32'h0F0F_0F0F);
        single(32'h0000_1002, 1'b0, 3'd0, 32'h0, rd, w, rdat);
        chk("R7 hrdata whole word", rd, 32'h0F0F_0F0F);
        chk("R8 byte read lane", rdat, 32'h000F_0000);
    endtask

    task automatic t_half();
        logic [31:0] rd, rdat;
        int w;
        single(32'h0000_1006, 1'b1, 3'd1, 32'hBEEF_BEEF, rd, w, rdat);
        chk("R8 upper half lanes", rdat, 32'hBEEF_0000);
        single(32'h0000_1004, 1'b1, 3'd1, 32'h1234_1234, rd, w, rdat);
        chk("R8 lower half lanes", rdat, 32'h0000_1234);
        single(32'h0000_1004, 1'b0, 3'd2, 32'h0, rd, w, rdat);
        chk("R7 halfwords assemble", rd, 32'hBEEF_1234);
    endtask

    task automatic t_incr_burst();
        logic [31:0] rd, rdat, ra;
        logic rv;
        int w;
        xfer(2'd2, 32'h0000_1010, 1'b1, 3'd2, 3'd3, 32'h1111_0000, 2'd1, rd, w, rv, ra, rdat);
        chk("R3 burst first waits", w, 2);
        for (int i = 1; i < 4; i++) begin
            // SEQ beats drive misleading control: it must be ignored.
            xfer(2'd3, 32'h0000_2FFC, 1'b0, 3'd0, 3'd0, 32'h1111_0000 + i,
                 (i == 3) ? 2'd0 : 2'd1, rd, w, rv, ra, rdat);
            chk("R4 later waits", w, 1);
            chk("R5 stepped addr", ra, 32'h0000_1010 + 4 * i);
            chk("R5 direction kept", {31'd0, rec_write}, 32'd1);
        end
        for (int i = 0; i < 4; i++) begin
            single(32'h0000_1010 + 4 * i, 1'b0, 3'd2, 32'h0, rd, w, rdat);
            chk("R5 burst data stored", rd, 32'h1111_0000 + i);
        end
    endtask

    task automatic t_wrap_burst();
        logic [31:0] rd, rdat, ra;
        logic [31:0] exp_a [4];
        logic rv;
        int w;
        exp_a = '{32'h1028, 32'h102C, 32'h1020, 32'h1024};
        xfer(2'd2, 32'h0000_1028, 1'b1, 3'd2, 3'd2, 32'hA0, 2'd1, rd, w, rv, ra, rdat);
        chk("R6 wrap4 beat0", ra, exp_a[0]);
        for (int i = 1; i < 4; i++) begin
            xfer(2'd3, 32'h0, 1'b0, 3'd2, 3'd2, 32'hA0 + i,
                 (i == 3) ? 2'd0 : 2'd1, rd, w, rv, ra, rdat);
            chk("R6 wrap4 word addr", ra, exp_a[i]);
        end
        single(32'h0000_1020, 1'b0, 3'd2, 32'h0, rd, w, rdat);
        chk("R6 wrapped word stored", rd, 32'hA2);
        exp_a = '{32'h2006, 32'h2000, 32'h2002, 32'h2004};
        xfer(2'd2, 32'h0000_2006, 1'b1, 3'd1, 3'd2, {2{16'hC000}}, 2'd1, rd, w, rv, ra, rdat);
        chk("R3 bank2 first waits", w, 3);
        chk("R6 wrap4 half beat0", ra, exp_a[0]);
        for (int i = 1; i < 4; i++) begin
            xfer(2'd3, 32'h0, 1'b0, 3'd2, 3'd0, {2{16'hC000 + 16'(i)}},
                 (i == 3) ? 2'd0 : 2'd1, rd, w, rv, ra, rdat);
            chk("R4 bank2 later waits", w, 0);
            chk("R6 wrap4 half addr", ra, exp_a[i]);
        end
        single(32'h0000_2000, 1'b0, 3'd2, 32'h0, rd, w, rdat);
        chk("R6 half wrap word0", rd, 32'hC002_C001);
        single(32'h0000_2004, 1'b0, 3'd2, 32'h0, rd, w, rdat);
        chk("R6 half wrap word1", rd, 32'hC000_C003);
    endtask

    task automatic t_idle_ignored();
        logic [31:0] rd, rdat;
        int w;
        for (int t = 0; t < 2; t++) begin
            @(negedge clk);
            hsel = 1'b1; htrans = 2'(t); haddr = 32'h0000_0008; hwrite = 1'b1;
            hsize = 3'd2; hburst = 3'd0;
            @(posedge clk);
            #1;
            hwdata = 32'hFFFF_FFFF;
            htrans = 2'd0;
            @(negedge clk);
            chk("R10 no record", {31'd0, rec_valid}, 32'd0);
        end
        single(32'h0000_0008, 1'b0, 3'd2, 32'h0, rd, w, rdat);
        chk("R10 storage kept", rd, 32'hA5A5_5A5A);
    endtask

    task automatic t_miss_and_edges();
        logic [31:0] rd, rdat;
        int w;
        single(32'h0000_5000, 1'b1, 3'd2, 32'h7777_7777, rd, w, rdat);
        chk("R11 miss write no wait", w, 0);
        single(32'h0000_5000, 1'b0, 3'd2, 32'h0, rd, w, rdat);
        chk("R11 miss read zero", rd, 32'h0);
        single(32'h0000_00FC, 1'b1, 3'd2, 32'h5EED_0001, rd, w, rdat);
        single(32'h0000_00FC, 1'b0, 3'd2, 32'h0, rd, w, rdat);
        chk("R2 last word of bank0", rd, 32'h5EED_0001);
        single(32'h0000_0100, 1'b0, 3'd2, 32'h0, rd, w, rdat);
        chk("R2 past bank0 end", rd, 32'h0);
        single(32'h0000_10FC, 1'b0, 3'd2, 32'h0, rd, w, rdat);
        chk("R2 bank1 end hit", w, 2);
        single(32'h0000_1100, 1'b0, 3'd2, 32'h0, rd, w, rdat);
        chk("R2 bank1 end miss", w, 0);
    endtask

    initial begin
        hresetn = 1'b0;
        hsel = 1'b0; haddr = '0; htrans = 2'd0; hwrite = 1'b0;
        hsize = 3'd0; hburst = 3'd0; hwdata = '0;
        cfg_start = '0; cfg_end = '0; cfg_wait_first = '0; cfg_wait_next = '0;
        cfg_start[0*AW +: AW] = 32'h0000_0000; cfg_end[0*AW +: AW] = 32'h0000_00FF;
        cfg_start[1*AW +: AW] = 32'h0000_1000; cfg_end[1*AW +: AW] = 32'h0000_10FF;
        cfg_wait_first[1*WW +: WW] = 8'd2;     cfg_wait_next[1*WW +: WW] = 8'd1;
        cfg_start[2*AW +: AW] = 32'h0000_2000; cfg_end[2*AW +: AW] = 32'h0000_20FF;
        cfg_wait_first[2*WW +: WW] = 8'd3;     cfg_wait_next[2*WW +: WW] = 8'd0;
        repeat (3) @(negedge clk);
        t_reset();
        t_zero_wait();
        t_byte_lanes();
        t_half();
        t_incr_burst();
        t_wrap_burst();
        t_idle_ignored();
        t_miss_and_edges();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule